// File: doc/BRIEF.md
# Carrier-Period Interrupt Decimation Counter

This block sits beside a PWM carrier timer and thins out its period events into a slower interrupt request. A small reload register holds a divide ratio n. The block counts qualifying events and raises a single-cycle interrupt request on every n-th one. The one exception is the first request after the ratio is loaded, which comes one event early, after n-1 events.

Which events count depends on a mode bit. In the fixed mode only the carrier timer underflow pulse counts. In the selectable mode a source-select bit chooses between that underflow pulse and an edge of a reload-control level supplied by a phase timer. A polarity bit picks the rising or the falling edge. Edges are found by comparing the level with its registered value from the previous cycle. The interrupt controller and the timers themselves lie outside the block.

Top module: `carrier_irq_decimator`

## Requirements
- R1: While `rst_n` is low, `irq_o` is held low. After reset the stored ratio is 0 and the reload-control history is 0.
- R2: With `mode_i` = 0, every cycle with `carrier_uf_i` = 1 is a counted event, whatever `src_sel_i` and `edge_pol_i` are. Changes on `rl_ctrl_i` are not counted.
- R3: With `mode_i` = 1 and `src_sel_i` = 0, every cycle with `carrier_uf_i` = 1 is a counted event.
- R4: With `mode_i` = 1, `src_sel_i` = 1 and `edge_pol_i` = 0, a cycle where `rl_ctrl_i` is 1 and its previous-cycle value is 0 is a counted event. Underflow pulses are then not counted.
- R5: With `mode_i` = 1, `src_sel_i` = 1 and `edge_pol_i` = 1, a cycle where `rl_ctrl_i` is 0 and its previous-cycle value is 1 is a counted event.
- R6: After a load with ratio n ≥ 2, the first interrupt comes on the (n-1)-th counted event.
- R7: After each interrupt, the next one comes on the n-th following counted event.
- R8: A ratio of 0 or 1 gives an interrupt on every counted event.
- R9: A cycle with `reload_wr_i` = 1 stores `reload_val_i` and restarts the count. An event in that same cycle is not counted and raises no interrupt.
- R10: `irq_o` is high for exactly the cycle of the terminal event, with no register delay.
- R11: The previous-cycle value of `rl_ctrl_i` is captured every cycle, whatever the mode. Because the history resets to 0, a level of 1 in the first cycle after reset is a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reload_wr_i | input | 1 | Load strobe for the ratio; restarts the count |
| reload_val_i | input | CNT_W (4) | Divide ratio n |
| mode_i | input | 1 | 0: underflow only; 1: source selectable |
| src_sel_i | input | 1 | In mode 1: 0 underflow, 1 reload-control edge |
| edge_pol_i | input | 1 | 0 rising edge, 1 falling edge |
| carrier_uf_i | input | 1 | Carrier timer underflow pulse |
| rl_ctrl_i | input | 1 | Reload-control level from a phase timer |
| irq_o | output | 1 | Single-cycle interrupt request |

## Verification
The bench targets several corner cases.

- **Early first interrupt.** A design that ignores it fires the first request one event late, or shifts every later period as well.
- **Ratios 0 and 1.** A design that treats them as a full wrap would either go silent or wait 16 events.
- **Load coinciding with an event.** A wrong design would count that event and shift the whole train by one.
- **Source gating by mode.** With `mode_i` = 0, reload-control edges must not count. A wrong design would produce extra requests on edges, or miss underflows.
- **Edge history.** The bench toggles the reload-control level with polarity changes and resets while the level is high. A design that updates its history only in mode 1, or resets it to 1, would miss or invent an edge.

// File: rtl/icdec_pkg.sv
// Package: shared encodings for the carrier interrupt decimation counter.
// Assumes: single clock domain, 1-bit control fields.
package icdec_pkg;

    // Operating mode: fixed underflow counting, or selectable source.
    typedef enum logic {
        MODE_FIXED  = 1'b0,
        MODE_SELECT = 1'b1
    } mode_e;

    // Count source when the selectable mode is active.
    typedef enum logic {
        SRC_UNDERFLOW   = 1'b0,
        SRC_RELOAD_EDGE = 1'b1
    } src_e;

    // Edge polarity of the reload-control signal.
    typedef enum logic {
        EDGE_RISING  = 1'b0,
        EDGE_FALLING = 1'b1
    } pol_e;

endpackage

// File: rtl/icdec_edge_detect.sv
// Module: icdec_edge_detect
// Registers a level every cycle and flags rising and falling transitions
// relative to the previous cycle's value. Assumes the input is already
// synchronous to clk. The history resets to RESET_LEVEL.
module icdec_edge_detect #(
    parameter bit RESET_LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise_o,
    output logic fall_o
);

    logic hist_q;

    // Capture the level for comparison in the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= RESET_LEVEL;
        else        hist_q <= sig_i;
    end

    // Compare the present level with the captured one.
    always_comb begin
        rise_o = sig_i & ~hist_q;
        fall_o = ~sig_i & hist_q;
    end

    // R4 R5: at most one transition direction is reported per cycle
    edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rise_o, fall_o}));

    // R11
    no_double_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

    // R11
    no_double_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);

endmodule

// File: rtl/icdec_event_sel.sv
// Module: icdec_event_sel
// Chooses which pulse counts as an event. In the fixed mode only the
// underflow pulse counts. In the selectable mode the source bit picks
// underflow or one reload-control edge, chosen by the polarity bit.
// Purely combinational; assumes single-cycle input pulses.
module icdec_event_sel
    import icdec_pkg::*;
(
    input  logic mode_i,
    input  logic src_sel_i,
    input  logic edge_pol_i,
    input  logic uf_i,
    input  logic rise_i,
    input  logic fall_i,
    output logic evt_o
);

    logic edge_evt;

    // Choose the edge direction requested by the polarity bit.
    always_comb begin
        if (edge_pol_i == EDGE_FALLING) edge_evt = fall_i;
        else                            edge_evt = rise_i;
    end

    // Choose the event source, honouring the selector only in the selectable mode.
    always_comb begin
        if (mode_i == MODE_SELECT && src_sel_i == SRC_RELOAD_EDGE) evt_o = edge_evt;
        else                                                       evt_o = uf_i;
    end

endmodule

// File: rtl/icdec_decimator.sv
// Module: icdec_decimator
// Holds the divide ratio and the events still remaining before the next
// request. A load sets the first period to n-1 and each later one to n,
// with 0 and 1 treated as 1. The request is combinational on the terminal
// event. Assumes load and event are single-cycle strobes; load wins.
module icdec_decimator #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             evt_i,
    output logic             irq_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] ratio_q;
    logic [CNT_W-1:0] remain_q;
    logic [CNT_W-1:0] first_len;
    logic [CNT_W-1:0] period_len;
    logic             terminal;

    // Length of the first period after a load: n-1, at least one event.
    always_comb begin
        if (load_val_i <= ONE + ONE) first_len = ONE;
        else                         first_len = load_val_i - ONE;
    end

    // Length of each later period: n, at least one event.
    always_comb begin
        if (ratio_q <= ONE) period_len = ONE;
        else                period_len = ratio_q;
    end

    // Store the ratio on load.
    always_ff @(posedge clk) begin
        if (!rst_n)      ratio_q <= '0;
        else if (load_i) ratio_q <= load_val_i;
    end

    // Count events down to the terminal one, then reload the period.
    always_ff @(posedge clk) begin
        if (!rst_n)          remain_q <= ONE;
        else if (load_i)     remain_q <= first_len;
        else if (evt_i) begin
            if (terminal)    remain_q <= period_len;
            else             remain_q <= remain_q - ONE;
        end
    end

    // Flag the terminal event and raise the request in the same cycle.
    always_comb begin
        terminal = (remain_q == ONE);
        irq_o    = rst_n & evt_i & ~load_i & terminal;
    end

    // R7: the remaining count never reaches zero
    remain_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        remain_q != '0);

    // R7
    period_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> (remain_q == period_len));

    // R9
    load_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> !irq_o);

    // R10
    irq_needs_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> evt_i);

endmodule

// File: rtl/carrier_irq_decimator.sv
// Module: carrier_irq_decimator (top)
// Raises a one-cycle interrupt request every n counted carrier events.
// The first request after a load comes after n-1 events. Events are
// carrier underflows, or in the selectable mode optionally one edge of a
// reload-control level. Assumes synchronous inputs and single-cycle
// underflow pulses.
module carrier_irq_decimator #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload_wr_i,
    input  logic [CNT_W-1:0] reload_val_i,
    input  logic             mode_i,
    input  logic             src_sel_i,
    input  logic             edge_pol_i,
    input  logic             carrier_uf_i,
    input  logic             rl_ctrl_i,
    output logic             irq_o
);

    logic rl_rise;
    logic rl_fall;
    logic evt;

    // Find transitions of the reload-control level.
    icdec_edge_detect #(.RESET_LEVEL(1'b0)) i_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (rl_ctrl_i),
        .rise_o (rl_rise),
        .fall_o (rl_fall)
    );

    // Select the counted event.
    icdec_event_sel i_sel (
        .mode_i     (mode_i),
        .src_sel_i  (src_sel_i),
        .edge_pol_i (edge_pol_i),
        .uf_i       (carrier_uf_i),
        .rise_i     (rl_rise),
        .fall_i     (rl_fall),
        .evt_o      (evt)
    );

    // Divide the events down to interrupt requests.
    icdec_decimator #(.CNT_W(CNT_W)) i_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (reload_wr_i),
        .load_val_i (reload_val_i),
        .evt_i      (evt),
        .irq_o      (irq_o)
    );

    // R2
    fixed_mode_uf_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_i && !carrier_uf_i) |-> !irq_o);

    // R4
    rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i && src_sel_i && !edge_pol_i && irq_o) |-> (rl_ctrl_i && !rl_fall));

    // R5
    fall_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i && src_sel_i && edge_pol_i && irq_o) |-> (!rl_ctrl_i && !rl_rise));

    // R10
    single_pulse_uf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && (!mode_i || !src_sel_i)) |-> carrier_uf_i);

endmodule

// File: tb/test_carrier_irq_decimator.sv
// Bench: behavioural reference model compared with irq_o every cycle.
module test_carrier_irq_decimator;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reload_wr_i = 1'b0;
    logic [3:0] reload_val_i = '0;
    logic       mode_i = 1'b0;
    logic       src_sel_i = 1'b0;
    logic       edge_pol_i = 1'b0;
    logic       carrier_uf_i = 1'b0;
    logic       rl_ctrl_i = 1'b0;
    logic       irq_o;

    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;
    string tag = "R1";

    // Reference model state.
    int m_ratio = 0;
    int m_seen = 0;
    bit m_first = 1'b1;
    bit m_prev = 1'b0;

    always #4 clk = ~clk;

    carrier_irq_decimator i_carrier_irq_decimator (
        .clk          (clk),
        .rst_n        (rst_n),
        .reload_wr_i  (reload_wr_i),
        .reload_val_i (reload_val_i),
        .mode_i       (mode_i),
        .src_sel_i    (src_sel_i),
        .edge_pol_i   (edge_pol_i),
        .carrier_uf_i (carrier_uf_i),
        .rl_ctrl_i    (rl_ctrl_i),
        .irq_o        (irq_o)
    );

    // Drive one cycle, compare with the model, advance the model.
    task automatic cyc(input bit rst, input bit ld, input int val, input bit md,
                       input bit sel, input bit pol, input bit uf, input bit rl);
        bit exp_evt;
        bit exp_irq;
        int target;
        @(negedge clk);
        rst_n = ~rst; reload_wr_i = ld; reload_val_i = 4'(val);
        mode_i = md; src_sel_i = sel; edge_pol_i = pol;
        carrier_uf_i = uf; rl_ctrl_i = rl;
        #1;
        if (rst) begin
            exp_irq = 1'b0;
        end else begin
            if (md && sel) exp_evt = pol ? (m_prev && !rl) : (!m_prev && rl);
            else           exp_evt = uf;
            target = m_first ? m_ratio - 1 : m_ratio;
            if (target < 1) target = 1;
            exp_irq = !ld && exp_evt && (m_seen + 1 == target);
        end
        checks++;
        if (irq_o !== exp_irq) begin
            failures++;
            $display("FAIL %s irq_o actual=%b expected=%b at %0t", tag, irq_o, exp_irq, $time);
        end
        if (rst) begin
            m_ratio = 0; m_seen = 0; m_first = 1'b1; m_prev = 1'b0;
        end else begin
            m_prev = rl;
            if (ld) begin
                m_ratio = val; m_seen = 0; m_first = 1'b1;
            end else if (exp_evt) begin
                if (m_seen + 1 == target) begin m_seen = 0; m_first = 1'b0; end
                else m_seen++;
            end
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        failures++;
        $display("FAIL watchdog expired tag=%s actual=running expected=finished", tag);
        finish_run();
    end

    initial begin
        // R1: reset holds the request low even with events present
        tag = "R1";
        for (int i = 0; i < 4; i++) cyc(1, 0, 0, 0, 0, 0, 1, 0);
        // R8: ratio 0 after reset gives a request on every underflow
        tag = "R8";
        for (int i = 0; i < 6; i++) cyc(0, 0, 0, 0, 0, 0, i % 2, 0);
        // R2: fixed mode ignores selector, polarity and reload edges
        tag = "R2";
        cyc(0, 1, 3, 0, 1, 1, 0, 0);
        for (int i = 0; i < 24; i++) cyc(0, 0, 0, 0, 1, i % 3 == 0, i % 4 == 1, i % 2);
        // R3 R6 R7: selectable mode on underflow, n = 4
        tag = "R3";
        cyc(0, 1, 4, 1, 0, 0, 0, 0);
        tag = "R6";
        for (int i = 0; i < 6; i++) cyc(0, 0, 0, 1, 0, 0, 1, i % 2);
        tag = "R7";
        for (int i = 0; i < 20; i++) cyc(0, 0, 0, 1, 0, 1, i % 2, 1);
        // R4: rising edges, underflows ignored, n = 2
        tag = "R4";
        cyc(0, 1, 2, 1, 0, 0, 0, 0);
        for (int i = 0; i < 24; i++) cyc(0, 0, 0, 1, 1, 0, 1, (i / 2) % 2);
        // R5: falling edges, n = 5
        tag = "R5";
        cyc(0, 1, 5, 1, 0, 1, 0, 0);
        for (int i = 0; i < 40; i++) cyc(0, 0, 0, 1, 1, 1, i % 3 == 0, (i / 3) % 2);
        // R8: ratio 1
        tag = "R8";
        cyc(0, 1, 1, 0, 0, 0, 0, 0);
        for (int i = 0; i < 8; i++) cyc(0, 0, 0, 0, 0, 0, 1, 0);
        // R9: load mid-count with a coincident event, then restart
        tag = "R9";
        cyc(0, 1, 6, 0, 0, 0, 0, 0);
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 0, 0, 1, 0);
        cyc(0, 1, 3, 0, 0, 0, 1, 0);
        for (int i = 0; i < 8; i++) cyc(0, 0, 0, 0, 0, 0, 1, 0);
        cyc(0, 1, 0, 0, 0, 0, 1, 0);
        cyc(0, 0, 0, 0, 0, 0, 1, 0);
        // R11: history tracked in fixed mode, reset to 0
        tag = "R11";
        cyc(0, 1, 0, 0, 0, 0, 0, 1);
        cyc(0, 0, 0, 1, 1, 0, 0, 1);
        cyc(1, 0, 0, 1, 1, 0, 0, 1);
        cyc(0, 0, 0, 1, 1, 0, 0, 1);
        cyc(0, 0, 0, 1, 1, 0, 0, 1);
        // R10: random mix, request only in the terminal cycle
        tag = "R10";
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = int'($urandom_range(0, 1023));
            cyc(r % 97 == 0, r % 41 == 0, r % 16, (r / 7) % 2, (r / 11) % 2,
                (r / 13) % 2, (r / 3) % 3 == 0, (r / 5) % 2);
        end
        finish_run();
    end

endmodule